// File: doc/BRIEF.md
# Three-Lane DDS Serial Word Loader

This block drives three serial direct-digital-synthesis devices at once. All three devices share one shift clock and one active-low frame line. Each device has its own data lane, so a single 16-bit transfer loads all three devices together. The content of each lane can differ: per-channel phase words use a different value on each lane, while control and frequency words use the same value on every lane.

A host issues commands over a valid/ready command port. The command set covers:
- a single word sent to all lanes;
- the device reset word;
- per-channel or shared phase words;
- a three-word retune (phase, then the low frequency half, then the high frequency half);
- a nine-word power-up sequence.

The loader generates all bit timing and the gaps between words. It holds `busy` for the whole sequence and ends each command with a one-cycle `cmd_done` pulse. Back-pressure: `cmd_ready` is high only while the loader is idle. A command transfers on a cycle with `cmd_valid` and `cmd_ready` both high, and all operands are captured on that cycle. An offer made while `cmd_ready` is low is not taken. If the host keeps the offer up, it is taken on the first idle cycle after `cmd_done`.

Top module: `dds3_word_loader`

## Requirements
- R1: `cmd_ready` is high exactly when the loader is idle. On the cycle after a transfer, `busy` is high and `cmd_ready` is low. Operands are sampled at the transfer, so later changes to `cmd_word`, `phase_ch*` or `freq_word` do not alter the words sent. An offer withdrawn while busy never causes a transfer.
- R2: `busy` stays high from the cycle after the transfer through the `cmd_done` cycle. `cmd_done` is a single-cycle pulse, issued exactly once per command. For a command that sends words, `cmd_done` is high on the cycle after the frame line returns high at the end of the final word. `busy` is low the cycle after `cmd_done`.
- R3: Each word holds `dds_frame_n` low for exactly 33×HALF_CYCLES clock cycles. It carries 16 falling edges of `dds_sclk`, most significant bit first. The shift clock is high whenever the frame line is high.
- R4: Each clock level lasts HALF_CYCLES cycles. Data lanes change only while `dds_sclk` is high and are stable while it is low; devices sample on the falling edge.
- R5: All data lanes are low whenever `dds_frame_n` is high.
- R6: Opcode 0 sends `cmd_word` on all lanes. Opcode 1 sends 0x2100 on all lanes.
- R7: Opcode 2 sends 0xC000|phase_chN on lane N. Opcode 3 sends 0xC000|cmd_word[11:0] on every lane.
- R8: Opcode 4 sends three words in order:
  - the per-lane phase word;
  - 0x4000|freq_word[13:0];
  - 0x4000|freq_word[27:14].

  Both frequency words are identical on all lanes.
- R9: Between consecutive words of one command the frame line stays high for exactly GAP_SHORT+2 cycles, except where R10 specifies GAP_LONG.
- R10: Opcode 5 sends nine words in order:
  - 0x2100;
  - a retune;
  - 0xC000 on all lanes;
  - 0x2000;
  - a second retune.

  The gap after 0x2100 and after 0x2000 is GAP_LONG+2 frame-high cycles.
- R11: Opcodes 6 and 7 are accepted and answered with a `cmd_done` pulse one cycle after the transfer. No serial line moves.
- R12: During and after reset the outputs are idle: frame high, clock high, data low, `busy` low, `cmd_done` low, `cmd_ready` high. This also holds when reset arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offer |
| cmd_ready | output | 1 | Loader idle and able to take a command |
| cmd_op | input | 3 | Command opcode (0..5 defined) |
| cmd_word | input | 16 | Raw word (op 0) or shared phase in bits 11:0 (op 3) |
| phase_ch0 | input | 12 | Phase for lane 0 |
| phase_ch1 | input | 12 | Phase for lane 1 |
| phase_ch2 | input | 12 | Phase for lane 2 |
| freq_word | input | 28 | Frequency tuning value, split into two 14-bit halves |
| busy | output | 1 | Sequence in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| dds_frame_n | output | 1 | Shared active-low frame line |
| dds_sclk | output | 1 | Shared shift clock |
| dds_sdata | output | 3 | Per-lane serial data, bit N to device N |

## Verification
The embedded assertions cover the cycle-level invariants on every clock:
- quiet data lanes outside a frame;
- the clock idling high;
- stable data while the clock is low;
- one-cycle `cmd_done` inside `busy`;
- serializer starts only when it is idle.

Word content, bit order, exact frame length, the short and long gap lengths, the nine-word power-up order and operand capture at the handshake only show up in whole command scenarios. The bench decodes the three lanes at each falling clock edge and compares them with a model of each opcode.

// File: rtl/dds3_pkg.sv
package dds3_pkg;

  localparam int NUM_LANES = 3;
  localparam int WORD_W    = 16;
  localparam int PHASE_W   = 12;
  localparam int FHALF_W   = 14;
  localparam int FREQ_W    = 2 * FHALF_W;
  localparam int OP_W      = 3;
  localparam int IDX_W     = 4;
  localparam int BIT_W     = $clog2(WORD_W);

  localparam logic [OP_W-1:0] OP_WORD   = 3'd0;
  localparam logic [OP_W-1:0] OP_RESET  = 3'd1;
  localparam logic [OP_W-1:0] OP_PH_IND = 3'd2;
  localparam logic [OP_W-1:0] OP_PH_COM = 3'd3;
  localparam logic [OP_W-1:0] OP_RETUNE = 3'd4;
  localparam logic [OP_W-1:0] OP_INIT   = 3'd5;

  localparam logic [WORD_W-1:0] W_HOLD_RESET = 16'h2100;
  localparam logic [WORD_W-1:0] W_RUN        = 16'h2000;
  localparam logic [WORD_W-1:0] W_PHASE_TAG  = 16'hC000;
  localparam logic [1:0]        FREQ_TAG     = 2'b01;

  typedef enum logic [2:0] {
    K_CONST, K_CMD, K_PH_IND, K_PH_COM, K_FLO, K_FHI
  } kind_e;

  typedef enum logic [1:0] {G_NONE, G_SHORT, G_LONG} gap_e;

  typedef struct packed {
    kind_e              kind;
    logic [WORD_W-1:0]  konst;
    gap_e               gap;
    logic               last;
  } step_t;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return op <= OP_INIT;
  endfunction

  // One word of a phase/low/high retune group; the high half closes the group.
  function automatic step_t retune_step(input logic [IDX_W-1:0] j, input logic closes);
    step_t s;
    s.konst = '0;
    s.gap   = G_SHORT;
    s.last  = 1'b0;
    case (j)
      4'd0:    s.kind = K_PH_IND;
      4'd1:    s.kind = K_FLO;
      default: begin
        s.kind = K_FHI;
        s.last = closes;
        s.gap  = closes ? G_NONE : G_SHORT;
      end
    endcase
    return s;
  endfunction

  function automatic step_t prog_step(input logic [OP_W-1:0] op, input logic [IDX_W-1:0] idx);
    step_t s;
    s = '{kind: K_CONST, konst: W_HOLD_RESET, gap: G_NONE, last: 1'b1};
    case (op)
      OP_WORD:   s.kind = K_CMD;
      OP_RESET:  s.konst = W_HOLD_RESET;
      OP_PH_IND: s.kind = K_PH_IND;
      OP_PH_COM: s.kind = K_PH_COM;
      OP_RETUNE: s = retune_step(idx, 1'b1);
      OP_INIT: begin
        case (idx)
          4'd0:               s = '{kind: K_CONST, konst: W_HOLD_RESET, gap: G_LONG, last: 1'b0};
          4'd1, 4'd2, 4'd3:   s = retune_step(idx - 4'd1, 1'b0);
          4'd4:               s = '{kind: K_CONST, konst: W_PHASE_TAG, gap: G_SHORT, last: 1'b0};
          4'd5:               s = '{kind: K_CONST, konst: W_RUN, gap: G_LONG, last: 1'b0};
          default:            s = retune_step(idx - 4'd6, 1'b1);
        endcase
      end
      default: s = '{kind: K_CONST, konst: '0, gap: G_NONE, last: 1'b1};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/dds3_word_builder.sv
module dds3_word_builder
  import dds3_pkg::*;
(
  input  step_t                                 step_i,
  input  logic [WORD_W-1:0]                     cmd_word_i,
  input  logic [NUM_LANES-1:0][PHASE_W-1:0]     phases_i,
  input  logic [FREQ_W-1:0]                     freq_i,
  output logic [NUM_LANES-1:0][WORD_W-1:0]      words_o
);

  logic [WORD_W-1:0] freq_lo_w, freq_hi_w, shared_phase_w;

  assign freq_lo_w      = {FREQ_TAG, freq_i[FHALF_W-1:0]};
  assign freq_hi_w      = {FREQ_TAG, freq_i[FREQ_W-1:FHALF_W]};
  assign shared_phase_w = W_PHASE_TAG | {{(WORD_W-PHASE_W){1'b0}}, cmd_word_i[PHASE_W-1:0]};

  for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
    always_comb begin
      case (step_i.kind)
        K_CONST:  words_o[ln] = step_i.konst;
        K_CMD:    words_o[ln] = cmd_word_i;
        K_PH_IND: words_o[ln] = W_PHASE_TAG | {{(WORD_W-PHASE_W){1'b0}}, phases_i[ln]};
        K_PH_COM: words_o[ln] = shared_phase_w;
        K_FLO:    words_o[ln] = freq_lo_w;
        default:  words_o[ln] = freq_hi_w;
      endcase
    end
  end

endmodule

// File: rtl/dds3_shifter.sv
module dds3_shifter
  import dds3_pkg::*;
#(
  parameter int HALF_CYCLES = 4
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start_i,
  input  logic [NUM_LANES-1:0][WORD_W-1:0]   words_i,
  output logic                               idle_o,
  output logic                               done_o,
  output logic                               frame_n_o,
  output logic                               sclk_o,
  output logic [NUM_LANES-1:0]               sdata_o
);

  localparam int HT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [HT_W-1:0] HT_LOAD = HT_W'(HALF_CYCLES - 1);

  typedef enum logic [1:0] {SH_IDLE, SH_SETUP, SH_LOW, SH_TAIL} sh_state_e;

  sh_state_e                            st;
  logic [HT_W-1:0]                      tmr;
  logic [BIT_W-1:0]                     bitn;
  logic [NUM_LANES-1:0][WORD_W-1:0]     sh;

  assign idle_o = (st == SH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SH_IDLE;
      tmr       <= '0;
      bitn      <= '0;
      sh        <= '0;
      done_o    <= 1'b0;
      frame_n_o <= 1'b1;
      sclk_o    <= 1'b1;
      sdata_o   <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        SH_IDLE: begin
          if (start_i) begin
            st        <= SH_SETUP;
            tmr       <= HT_LOAD;
            bitn      <= '0;
            frame_n_o <= 1'b0;
            sclk_o    <= 1'b1;
            for (int l = 0; l < NUM_LANES; l++) begin
              sdata_o[l] <= words_i[l][WORD_W-1];
              sh[l]      <= {words_i[l][WORD_W-2:0], 1'b0};
            end
          end
        end
        SH_SETUP: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            st     <= SH_LOW;
            tmr    <= HT_LOAD;
            sclk_o <= 1'b0;
          end
        end
        SH_LOW: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            tmr    <= HT_LOAD;
            sclk_o <= 1'b1;
            if (bitn == BIT_W'(WORD_W - 1)) begin
              st      <= SH_TAIL;
              sdata_o <= '0;
            end else begin
              st   <= SH_SETUP;
              bitn <= bitn + 1'b1;
              for (int l = 0; l < NUM_LANES; l++) begin
                sdata_o[l] <= sh[l][WORD_W-1];
                sh[l]      <= {sh[l][WORD_W-2:0], 1'b0};
              end
            end
          end
        end
        default: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            st        <= SH_IDLE;
            frame_n_o <= 1'b1;
            done_o    <= 1'b1;
          end
        end
      endcase
    end
  end

  // R5: lanes are quiet outside a frame
  assert_lanes_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_o |-> (sdata_o == '0));

  // R3: shift clock idles high between frames
  assert_clock_idle_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_n_o |-> sclk_o);

  // R4: data holds through the low phase of the clock
  assert_data_stable_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_o && $past(!sclk_o)) |-> $stable(sdata_o));

  // R3: a new word is requested only once the previous frame is closed
  assert_start_when_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (idle_o && frame_n_o));

endmodule

// File: rtl/dds3_sequencer.sv
module dds3_sequencer
  import dds3_pkg::*;
#(
  parameter int GAP_SHORT = 800,
  parameter int GAP_LONG  = 2000
)(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cmd_valid,
  output logic                               cmd_ready,
  input  logic [OP_W-1:0]                    cmd_op,
  input  logic [WORD_W-1:0]                  cmd_word,
  input  logic [NUM_LANES-1:0][PHASE_W-1:0]  phases,
  input  logic [FREQ_W-1:0]                  freq_word,
  output logic                               busy,
  output logic                               cmd_done,
  output logic                               shf_start,
  input  logic                               shf_done,
  input  logic                               shf_idle,
  output step_t                              step_o,
  output logic [WORD_W-1:0]                  word_q_o,
  output logic [NUM_LANES-1:0][PHASE_W-1:0]  phases_q_o,
  output logic [FREQ_W-1:0]                  freq_q_o
);

  localparam int GAP_MAX = (GAP_LONG > GAP_SHORT) ? GAP_LONG : GAP_SHORT;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam logic [GAP_W-1:0] GAP_S_LOAD = GAP_W'(GAP_SHORT - 1);
  localparam logic [GAP_W-1:0] GAP_L_LOAD = GAP_W'(GAP_LONG - 1);

  typedef enum logic [2:0] {SQ_IDLE, SQ_ISSUE, SQ_SHIFT, SQ_GAP, SQ_FIN} sq_state_e;

  sq_state_e         state;
  logic [OP_W-1:0]   op_q;
  logic [IDX_W-1:0]  idx;
  logic [GAP_W-1:0]  gap_tmr;
  step_t             cur;

  assign cur       = prog_step(op_q, idx);
  assign step_o    = cur;
  assign cmd_ready = (state == SQ_IDLE);
  assign busy      = (state != SQ_IDLE);
  assign cmd_done  = (state == SQ_FIN);
  assign shf_start = (state == SQ_ISSUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= SQ_IDLE;
      op_q       <= '0;
      idx        <= '0;
      gap_tmr    <= '0;
      word_q_o   <= '0;
      phases_q_o <= '0;
      freq_q_o   <= '0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (cmd_valid) begin
            op_q       <= cmd_op;
            word_q_o   <= cmd_word;
            phases_q_o <= phases;
            freq_q_o   <= freq_word;
            idx        <= '0;
            state      <= op_known(cmd_op) ? SQ_ISSUE : SQ_FIN;
          end
        end
        SQ_ISSUE: state <= SQ_SHIFT;
        SQ_SHIFT: begin
          if (shf_done) begin
            if (cur.last) state <= SQ_FIN;
            else begin
              gap_tmr <= (cur.gap == G_LONG) ? GAP_L_LOAD : GAP_S_LOAD;
              state   <= SQ_GAP;
            end
          end
        end
        SQ_GAP: begin
          if (gap_tmr == '0) begin
            idx   <= idx + 1'b1;
            state <= SQ_ISSUE;
          end else begin
            gap_tmr <= gap_tmr - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R2: completion is a single-cycle pulse
  assert_done_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> !cmd_done);

  // R2: completion is reported inside the busy window
  assert_done_within_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> busy);

  // R1: a transfer closes the command port on the next cycle
  assert_accept_closes_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (busy && !cmd_ready));

  // R11: undefined opcodes never reach the serializer
  assert_no_start_undefined_R11: assert property (@(posedge clk) disable iff (!rst_n)
    shf_start |-> op_known(op_q));

  // R9: the serializer only finishes a word the sequencer is waiting on
  assert_word_end_awaited_R9: assert property (@(posedge clk) disable iff (!rst_n)
    shf_done |-> (state == SQ_SHIFT && !shf_start));

  // R3: the serializer is idle whenever the sequencer leaves a gap
  assert_gap_line_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_GAP) |-> shf_idle);

endmodule

// File: rtl/dds3_word_loader.sv
module dds3_word_loader
  import dds3_pkg::*;
#(
  parameter int HALF_CYCLES = 4,
  parameter int GAP_SHORT   = 800,
  parameter int GAP_LONG    = 2000
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic [OP_W-1:0]        cmd_op,
  input  logic [WORD_W-1:0]      cmd_word,
  input  logic [PHASE_W-1:0]     phase_ch0,
  input  logic [PHASE_W-1:0]     phase_ch1,
  input  logic [PHASE_W-1:0]     phase_ch2,
  input  logic [FREQ_W-1:0]      freq_word,
  output logic                   busy,
  output logic                   cmd_done,
  output logic                   dds_frame_n,
  output logic                   dds_sclk,
  output logic [NUM_LANES-1:0]   dds_sdata
);

  logic [NUM_LANES-1:0][PHASE_W-1:0] phases_in, phases_q;
  logic [NUM_LANES-1:0][WORD_W-1:0]  lane_words;
  logic [WORD_W-1:0]                 word_q;
  logic [FREQ_W-1:0]                 freq_q;
  step_t                             step;
  logic                              shf_start, shf_done, shf_idle;

  assign phases_in = {phase_ch2, phase_ch1, phase_ch0};

  dds3_sequencer #(
    .GAP_SHORT (GAP_SHORT),
    .GAP_LONG  (GAP_LONG)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_word   (cmd_word),
    .phases     (phases_in),
    .freq_word  (freq_word),
    .busy       (busy),
    .cmd_done   (cmd_done),
    .shf_start  (shf_start),
    .shf_done   (shf_done),
    .shf_idle   (shf_idle),
    .step_o     (step),
    .word_q_o   (word_q),
    .phases_q_o (phases_q),
    .freq_q_o   (freq_q)
  );

  dds3_word_builder build_i (
    .step_i     (step),
    .cmd_word_i (word_q),
    .phases_i   (phases_q),
    .freq_i     (freq_q),
    .words_o    (lane_words)
  );

  dds3_shifter #(
    .HALF_CYCLES (HALF_CYCLES)
  ) shift_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (shf_start),
    .words_i   (lane_words),
    .idle_o    (shf_idle),
    .done_o    (shf_done),
    .frame_n_o (dds_frame_n),
    .sclk_o    (dds_sclk),
    .sdata_o   (dds_sdata)
  );

  // R2: the serial lines only frame a word while a command is in flight
  assert_frame_inside_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dds_frame_n |-> busy);

endmodule

// File: tb/dds3_word_loader_tb_top.sv
`timescale 1ns/1ps
module dds3_word_loader_tb_top;

  localparam int HALF = 2;
  localparam int GS   = 20;
  localparam int GL   = 60;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [15:0] cmd_word = '0;
  logic [11:0] ph0 = '0, ph1 = '0, ph2 = '0;
  logic [27:0] freq = '0;
  logic        cmd_ready, busy, cmd_done, frame_n, sclk;
  logic [2:0]  sdata;

  always #2.5 clk = ~clk;

  dds3_word_loader #(.HALF_CYCLES(HALF), .GAP_SHORT(GS), .GAP_LONG(GL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_word(cmd_word), .phase_ch0(ph0), .phase_ch1(ph1),
    .phase_ch2(ph2), .freq_word(freq), .busy(busy), .cmd_done(cmd_done),
    .dds_frame_n(frame_n), .dds_sclk(sclk), .dds_sdata(sdata));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- line monitor ----------------
  logic [15:0] cap [3][16];
  int cap_low [16], cap_gap [16], cap_bits [16];
  int cap_n = 0, bit_k = 0, hi_run = 0, lo_run = 0;
  int stab_err = 0, quiet_err = 0, idle_err = 0;
  int done_cnt = 0, done_cyc = -1, rise_cyc = -1;
  bit pf = 1'b1, ps = 1'b1;
  logic [2:0] psd = '0;

  always @(negedge clk) begin
    cyc++;
    if (cmd_done) begin done_cnt++; done_cyc = cyc; end
    if (frame_n) begin
      if (sdata != 3'b000) quiet_err++;
      if (!sclk) idle_err++;
      if (!pf) begin
        if (cap_n < 16) begin cap_low[cap_n] = lo_run; cap_bits[cap_n] = bit_k; end
        cap_n++;
        rise_cyc = cyc;
        hi_run = 1;
      end else hi_run++;
    end else begin
      if (pf) begin
        if (cap_n > 0 && cap_n <= 16) cap_gap[cap_n-1] = hi_run;
        lo_run = 1;
        bit_k = 0;
      end else lo_run++;
      if (ps && !sclk) begin
        if (cap_n < 16)
          for (int l = 0; l < 3; l++) cap[l][cap_n] = {cap[l][cap_n][14:0], sdata[l]};
        bit_k++;
      end
      if (!sclk && !ps && sdata != psd) stab_err++;
    end
    pf = frame_n; ps = sclk; psd = sdata;
  end

  task automatic clear_mon();
    cap_n = 0; stab_err = 0; quiet_err = 0; idle_err = 0;
    done_cnt = 0; done_cyc = -1; rise_cyc = -1;
  endtask

  // ---------------- expected-value model ----------------
  function automatic int m_len(input logic [2:0] op);
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: return 1;
      3'd4: return 3;
      3'd5: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] m_retune(input int j, input logic [11:0] ph, input logic [27:0] f);
    if (j == 0) return 16'hC000 | {4'h0, ph};
    if (j == 1) return {2'b01, f[13:0]};
    return {2'b01, f[27:14]};
  endfunction

  function automatic logic [15:0] m_word(input logic [2:0] op, input int k, input int lane,
      input logic [15:0] w, input logic [11:0] a, input logic [11:0] b,
      input logic [11:0] c, input logic [27:0] f);
    logic [11:0] ph;
    ph = (lane == 0) ? a : (lane == 1) ? b : c;
    case (op)
      3'd0: return w;
      3'd1: return 16'h2100;
      3'd2: return 16'hC000 | {4'h0, ph};
      3'd3: return 16'hC000 | {4'h0, w[11:0]};
      3'd4: return m_retune(k, ph, f);
      default: begin
        if (k == 0) return 16'h2100;
        if (k <= 3) return m_retune(k - 1, ph, f);
        if (k == 4) return 16'hC000;
        if (k == 5) return 16'h2000;
        return m_retune(k - 6, ph, f);
      end
    endcase
  endfunction

  function automatic int m_gap(input logic [2:0] op, input int k);
    if (op == 3'd5 && (k == 0 || k == 5)) return GL + 2;
    return GS + 2;
  endfunction

  function automatic string m_req(input logic [2:0] op);
    case (op)
      3'd0, 3'd1: return "R6";
      3'd2, 3'd3: return "R7";
      3'd4: return "R8";
      3'd5: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic wait_done();
    int waited = 0;
    while (done_cnt == 0 && waited < 20000) begin @(negedge clk); waited++; end
    chk(done_cnt != 0, "R2", "done_timeout", waited, 0);
    repeat (4) @(negedge clk);
    #1;
  endtask

  task automatic run_cmd(input logic [2:0] op, input logic [15:0] w, input logic [11:0] a,
      input logic [11:0] b, input logic [11:0] c, input logic [27:0] f);
    int n;
    @(negedge clk); #1;
    clear_mon();
    cmd_op = op; cmd_word = w; ph0 = a; ph1 = b; ph2 = c; freq = f;
    chk(cmd_ready == 1'b1, "R1", "ready_before", cmd_ready, 1);
    cmd_valid = 1'b1;
    @(negedge clk); #1;
    chk(busy == 1'b1 && cmd_ready == 1'b0, "R1", "busy_ready_after_accept", {busy, cmd_ready}, 2'b10);
    cmd_valid = 1'b0;
    // R1: operands change after the transfer and must not matter
    cmd_word = ~w; ph0 = ~a; ph1 = ~b; ph2 = ~c; freq = ~f; cmd_op = 3'd0;
    wait_done();
    n = m_len(op);
    chk(cap_n == n, m_req(op), "word_count", cap_n, n);
    for (int k = 0; k < n && k < cap_n; k++) begin
      for (int l = 0; l < 3; l++)
        chk(cap[l][k] == m_word(op, k, l, w, a, b, c, f), m_req(op), "lane_word",
            cap[l][k], m_word(op, k, l, w, a, b, c, f));
      chk(cap_bits[k] == 16, "R3", "falling_edges", cap_bits[k], 16);
      chk(cap_low[k] == 33 * HALF, "R3", "frame_low_cycles", cap_low[k], 33 * HALF);
      if (k < n - 1)
        chk(cap_gap[k] == m_gap(op, k), (m_gap(op, k) == GL + 2) ? "R10" : "R9",
            "gap_cycles", cap_gap[k], m_gap(op, k));
    end
    chk(quiet_err == 0, "R5", "lane_active_outside_frame", quiet_err, 0);
    chk(stab_err == 0, "R4", "data_moved_while_clock_low", stab_err, 0);
    chk(idle_err == 0, "R3", "clock_low_outside_frame", idle_err, 0);
    chk(done_cnt == 1, "R2", "done_pulses", done_cnt, 1);
    if (n > 0) chk(done_cyc - rise_cyc == 1, "R2", "done_after_last_frame", done_cyc - rise_cyc, 1);
    else       chk(cap_n == 0, "R11", "no_line_activity", cap_n, 0);
    chk(busy == 1'b0 && cmd_ready == 1'b1, "R2", "idle_after_done", {busy, cmd_ready}, 2'b01);
  endtask

  // op, word, phase0, phase1, phase2, freq
  localparam int NV = 10;
  localparam logic [82:0] VEC [NV] = '{
    {3'd0, 16'hA5C3, 12'h000, 12'h000, 12'h000, 28'h0000000},
    {3'd0, 16'h0001, 12'h000, 12'h000, 12'h000, 28'h0000000},
    {3'd1, 16'h0000, 12'h000, 12'h000, 12'h000, 28'h0000000},
    {3'd2, 16'h0000, 12'h000, 12'h555, 12'hAAA, 28'h0000000},
    {3'd3, 16'hF123, 12'h111, 12'h222, 12'h333, 28'h0000000},
    {3'd4, 16'h0000, 12'd0,   12'd1365, 12'd2731, 28'h0ABCDEF},
    {3'd4, 16'h0000, 12'hFFF, 12'h800, 12'h001, 28'hFFFFFFF},
    {3'd5, 16'h0000, 12'h123, 12'h456, 12'h789, 28'h1234567},
    {3'd6, 16'hBEEF, 12'h000, 12'h000, 12'h000, 28'h0000000},
    {3'd7, 16'hBEEF, 12'h000, 12'h000, 12'h000, 28'h0000000}
  };

  initial begin : watchdog
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    // R12: outputs idle while reset is held
    repeat (3) @(negedge clk);
    #1;
    chk(frame_n && sclk && sdata == 3'b000, "R12", "lines_in_reset", {frame_n, sclk, sdata}, 5'b11000);
    chk(!busy && !cmd_done && cmd_ready, "R12", "status_in_reset", {busy, cmd_done, cmd_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(frame_n && sclk && sdata == 3'b000 && cmd_ready && !busy, "R12", "idle_after_reset",
        {frame_n, sclk, sdata, cmd_ready, busy}, 7'b1100010);

    for (int v = 0; v < NV; v++)
      run_cmd(VEC[v][82:80], VEC[v][79:64], VEC[v][63:52], VEC[v][51:40], VEC[v][39:28], VEC[v][27:0]);

    // R1: an offer made and withdrawn while busy is never taken
    begin
      int closed;
      closed = 0;
      @(negedge clk); #1;
      clear_mon();
      cmd_op = 3'd4; ph0 = 12'h010; ph1 = 12'h020; ph2 = 12'h030; freq = 28'h0C0FFEE;
      cmd_valid = 1'b1;
      @(negedge clk); #1;
      cmd_valid = 1'b0;
      repeat (30) @(negedge clk);
      #1;
      cmd_op = 3'd0; cmd_word = 16'h1234; cmd_valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk); #1;
        if (!cmd_ready) closed++;
      end
      cmd_valid = 1'b0;
      chk(closed == 5, "R1", "ready_low_while_busy", closed, 5);
      wait_done();
      chk(cap_n == 3, "R1", "withdrawn_offer_not_sent", cap_n, 3);
      chk(done_cnt == 1, "R1", "single_done_for_ignored_offer", done_cnt, 1);
    end

    // R12: reset in the middle of a power-up sequence returns the lines to idle
    @(negedge clk); #1;
    cmd_op = 3'd5; freq = 28'h0000100; cmd_valid = 1'b1;
    @(negedge clk); #1;
    cmd_valid = 1'b0;
    repeat (100) @(negedge clk);
    #1;
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk(frame_n && sclk && sdata == 3'b000, "R12", "lines_after_midseq_reset", {frame_n, sclk, sdata}, 5'b11000);
    chk(!busy && cmd_ready && !cmd_done, "R12", "status_after_midseq_reset", {busy, cmd_ready, cmd_done}, 3'b010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // loader still works after the interrupted sequence
    run_cmd(3'd0, 16'h8000, 12'h0, 12'h0, 12'h0, 28'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule